// File: doc/BRIEF.md
# Interrupt-capable GPIO port

This block is a 32-pin general-purpose I/O port behind a small memory-mapped register bus. Software drives pins through a data-out register, turns drivers on with an output-enable register and reads pin levels back through a data-in register. Each pin can also raise an interrupt. A per-pin level bit and polarity bit pick one of four sense modes. Pins admitted by a pin-to-interrupt select register latch their events into a sticky status register. Status is masked by an enable register and ORed into a single port interrupt line.

The registers sit in 16-byte slots. Inside a slot, the word at offset 0x0 is a plain write, 0x4 ORs the written word in, and 0x8 clears every bit that is set in the written word. Software can therefore change a single bit without a read-modify-write. Pin inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised level with its value one cycle earlier.

Top module: `gpio_irq_port`

## Requirements
- R1: Synchronous reset clears every register, including status, so that `pin_oe` is 0, `pin_out` is 0 and `irq` is 0.
- R2: Byte address bits [7:4] pick the slot and bits [3:2] pick the access. 0 replaces the register, 1 ORs `bus_wdata` in, 2 clears the bits that are 1 in `bus_wdata`, and 3 does nothing. A write with address bits [1:0] not zero is ignored. The slots are 0 data-out, 1 data-in, 2 output-enable, 3 pin-to-interrupt select, 4 interrupt enable, 5 level select, 6 polarity select and 7 status.
- R3: `pin_out` and `pin_oe` show the data-out and output-enable registers. A pin is driven only when its enable bit is 1. A read returns the register of the addressed slot at any of its access offsets, and 0 for slots 8 to 15.
- R4: A read of slot 1 returns `pin_in` delayed by two clock edges. Writes to slot 1 have no effect.
- R5: The 2-bit sense code of a pin is {polarity bit, level bit}: 00 falling edge, 01 low level, 10 rising edge, 11 high level. An input change made before clock edge k sets its status bit at edge k+2, so it is visible after the third edge.
- R6: In level mode a status bit is set on every cycle the active level is present. In edge mode it is set once per matching transition.
- R7: Status bits stay set until written with ones at the status clear offset (0x78). Plain writes and OR writes to slot 7 have no effect.
- R8: A pin whose pin-to-interrupt select bit is 0 never sets its status bit.
- R9: `irq` is high exactly when some bit is set in both status and interrupt enable. It follows enable writes without extra delay.
- R10: When a status bit is set by an event and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address: slot, access offset, alignment |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed slot (combinational) |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables, 1 = drive |
| irq | output | 1 | Combined port interrupt |

## Verification
Some rules are checked on every cycle. Status bits never fall without a clear-offset write in the cycle before. Unselected pins never raise status. A plain write to the output-enable slot appears on `pin_oe` one cycle later. `irq` stays low while enable is zero, and everything reads zero after reset. Only the bench scenarios can show the rest: the four sense codes and their three-edge latency, a held level re-setting status against a clear where an edge does not, the set-over-clear collision, and the data-in synchroniser delay.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [3:0] {
        SLOT_DOUT = 4'd0,
        SLOT_DIN  = 4'd1,
        SLOT_OE   = 4'd2,
        SLOT_SEL  = 4'd3,
        SLOT_EN   = 4'd4,
        SLOT_LVL  = 4'd5,
        SLOT_POL  = 4'd6,
        SLOT_STAT = 4'd7
    } slot_e;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_NONE  = 2'd3
    } access_e;

    localparam int NUM_SLOTS_USED = 8;

    // sense code {pol, lvl}: 00 fall, 01 low, 10 rise, 11 high
    function automatic logic sense_hit(input logic lvl, input logic pol,
                                       input logic cur, input logic prev);
        logic hit;
        case ({pol, lvl})
            2'b00:   hit = prev & ~cur;
            2'b01:   hit = ~cur;
            2'b10:   hit = cur & ~prev;
            default: hit = cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] cur,
    output logic [NPINS-1:0] prev
);
    logic [NPINS-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
            prev <= '0;
        end else begin
            stage[0] <= pin_in;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
            prev <= stage[STAGES-1];
        end
    end

    assign cur = stage[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  din,
    input  logic [NPINS-1:0]  status,
    output logic [NPINS-1:0]  dout,
    output logic [NPINS-1:0]  oe,
    output logic [NPINS-1:0]  sel,
    output logic [NPINS-1:0]  en,
    output logic [NPINS-1:0]  lvl,
    output logic [NPINS-1:0]  pol,
    output logic [NPINS-1:0]  stat_clr
);
    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot_idx;
    access_e           acc;
    logic              aligned;
    logic [NPINS-1:0]  view [NUM_SLOTS_USED];

    assign slot_idx = bus_addr[ADDR_W-1:4];
    assign acc      = access_e'(bus_addr[3:2]);
    assign aligned  = (bus_addr[1:0] == 2'b00);

    for (genvar g = 0; g < NUM_SLOTS_USED; g++) begin : g_reg
        logic [NPINS-1:0] q;
        if (g != int'(SLOT_DIN) && g != int'(SLOT_STAT)) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (bus_we && aligned && slot_idx == SLOT_W'(g)) begin
                    case (acc)
                        ACC_WRITE: q <= bus_wdata;
                        ACC_SET:   q <= q | bus_wdata;
                        ACC_CLR:   q <= q & ~bus_wdata;
                        default:   q <= q;
                    endcase
                end
            end
        end else if (g == int'(SLOT_DIN)) begin : g_din
            assign q = din;
        end else begin : g_stat
            assign q = status;
        end
        assign view[g] = q;
    end

    always_comb begin
        bus_rdata = '0;
        for (int s = 0; s < NUM_SLOTS_USED; s++)
            if (slot_idx == SLOT_W'(s)) bus_rdata = view[s];
    end

    assign stat_clr = (bus_we && aligned && slot_idx == SLOT_W'(SLOT_STAT)
                       && acc == ACC_CLR) ? bus_wdata : '0;

    assign dout = view[SLOT_DOUT];
    assign oe   = view[SLOT_OE];
    assign sel  = view[SLOT_SEL];
    assign en   = view[SLOT_EN];
    assign lvl  = view[SLOT_LVL];
    assign pol  = view[SLOT_POL];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] cur,
    input  logic [NPINS-1:0] prev,
    input  logic [NPINS-1:0] sel,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] status
);
    logic [NPINS-1:0] hit;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign hit[i] = sel[i] & sense_hit(lvl[i], pol[i], cur[i], prev[i]);
    end

    // a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr) | hit;
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] cur, prev;
    logic [NPINS-1:0] dout_q, oe_q, sel_q, en_q, lvl_q, pol_q;
    logic [NPINS-1:0] clr_mask, status_q;

    gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cur(cur), .prev(prev)
    );

    gpio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(cur),
        .status(status_q), .dout(dout_q), .oe(oe_q), .sel(sel_q),
        .en(en_q), .lvl(lvl_q), .pol(pol_q), .stat_clr(clr_mask)
    );

    gpio_detect #(.NPINS(NPINS)) i_detect (
        .clk(clk), .rst(rst), .cur(cur), .prev(prev), .sel(sel_q),
        .lvl(lvl_q), .pol(pol_q), .clr(clr_mask), .status(status_q)
    );

    assign pin_out = dout_q;
    assign pin_oe  = oe_q;
    assign irq     = |(status_q & en_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  irq_en,
    input logic [NPINS-1:0]  irq_sel
);
    localparam int SLOT_W = ADDR_W - 4;

    logic clr_wr, oe_wr;
    assign clr_wr = bus_we && bus_addr[1:0] == 2'b00
                 && bus_addr[ADDR_W-1:4] == SLOT_W'(SLOT_STAT)
                 && bus_addr[3:2] == 2'(ACC_CLR);
    assign oe_wr  = bus_we && bus_addr[1:0] == 2'b00
                 && bus_addr[ADDR_W-1:4] == SLOT_W'(SLOT_OE)
                 && bus_addr[3:2] == 2'(ACC_WRITE);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == '0 && pin_oe == '0 && !irq)); // R1

    AST_OE_WRITE: assert property (@(posedge clk) disable iff (rst)
        oe_wr |=> (pin_oe == $past(bus_wdata))); // R2

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(clr_wr) |-> (($past(status) & ~status) == '0)); // R7

    AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status) & ~$past(irq_sel)) == '0)); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq); // R9
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq(irq),
    .status(status_q), .irq_en(en_q), .irq_sel(sel_q)
);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
    logic        clk = 0;
    logic        rst = 1;
    logic        bus_we = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gpio_irq_port i_gpio_irq_port (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // slots and access offsets per R2
    localparam logic [3:0] S_DOUT = 0, S_DIN = 1, S_OE = 2, S_SEL = 3,
                           S_EN = 4, S_LVL = 5, S_POL = 6, S_STAT = 7;
    localparam logic [1:0] A_WR = 0, A_SET = 1, A_CLR = 2, A_NONE = 3;

    typedef struct packed {
        logic [3:0]  slot;
        logic [1:0]  acc;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{S_DOUT, A_WR,   32'hA5A5_0F0F, 32'hA5A5_0F0F},
        '{S_DOUT, A_SET,  32'h0000_F000, 32'hA5A5_FF0F},
        '{S_DOUT, A_CLR,  32'hA000_000F, 32'h05A5_FF00},
        '{S_DOUT, A_NONE, 32'hFFFF_FFFF, 32'h05A5_FF00},
        '{S_OE,   A_WR,   32'h1234_5678, 32'h1234_5678},
        '{S_EN,   A_SET,  32'h0000_00FF, 32'h0000_00FF},
        '{S_EN,   A_CLR,  32'h0000_000F, 32'h0000_00F0},
        '{S_LVL,  A_WR,   32'hFFFF_0000, 32'hFFFF_0000},
        '{S_STAT, A_WR,   32'hFFFF_FFFF, 32'h0000_0000},
        '{S_STAT, A_SET,  32'hFFFF_FFFF, 32'h0000_0000},
        '{S_DIN,  A_WR,   32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] slot, input logic [1:0] acc,
                      input logic [31:0] d);
        bus_we = 1; bus_addr = {slot, acc, 2'b00}; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] slot, output logic [31:0] d);
        bus_addr = {slot, A_WR, 2'b00};
        #1 d = bus_rdata;
    endtask

    task automatic reset_check(input string tag);
        logic [31:0] v;
        for (int s = 0; s < 8; s++) begin
            if (s != 1) begin
                rd(4'(s), v);
                check(tag, v, 32'h0);
            end
        end
        check(tag, {31'h0, irq}, 32'h0);
        check(tag, pin_oe, 32'h0);
        check(tag, pin_out, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst = 0;
        tick(1);
        reset_check("R1 initial");

        // R2 alias table, R4/R7 write no-effect rows
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].slot, VECS[i].acc, VECS[i].data);
            rd(VECS[i].slot, v);
            check($sformatf("R2 vector %0d", i), v, VECS[i].exp);
        end
        // R2 misaligned write ignored
        bus_we = 1; bus_addr = {S_OE, A_WR, 2'b01}; bus_wdata = 32'hFFFF_FFFF;
        tick(1); bus_we = 0;
        rd(S_OE, v); check("R2 misaligned", v, 32'h1234_5678);
        // R3 outputs and alias read, high slot reads 0
        check("R3 pin_out", pin_out, 32'h05A5_FF00);
        check("R3 pin_oe", pin_oe, 32'h1234_5678);
        bus_addr = {S_OE, A_CLR, 2'b00}; #1 check("R3 alias read", bus_rdata, 32'h1234_5678);
        bus_addr = 8'hC0; #1 check("R3 empty slot", bus_rdata, 32'h0);
        tick(1);

        // interrupt setup: pins 0..7 selected and enabled, edge mode
        wr(S_LVL, A_WR, 0); wr(S_POL, A_WR, 0);
        wr(S_SEL, A_WR, 32'hFF); wr(S_EN, A_WR, 32'hFF);
        wr(S_STAT, A_CLR, 32'hFFFF_FFFF);

        // R5 rising edge (code 10) on pin0, timing
        wr(S_POL, A_SET, 32'h1);
        pin_in[0] = 1;
        tick(2); check("R5 rise not yet", {31'h0, irq}, 32'h0);
        tick(1); check("R5 rise irq", {31'h0, irq}, 32'h1);
        rd(S_STAT, v); check("R5 rise status", v, 32'h1);
        // R6 edge: once only
        wr(S_STAT, A_CLR, 32'h1); tick(3);
        rd(S_STAT, v); check("R6 edge once", v, 32'h0);

        // R5/R6 high level (code 11) on pin1
        wr(S_LVL, A_SET, 32'h2); wr(S_POL, A_SET, 32'h2);
        pin_in[1] = 1; tick(3);
        rd(S_STAT, v); check("R5 high level", v, 32'h2);
        wr(S_STAT, A_CLR, 32'h2);
        rd(S_STAT, v); check("R6 level re-sets", v, 32'h2);
        pin_in[1] = 0; tick(3);
        wr(S_STAT, A_CLR, 32'h2);
        rd(S_STAT, v); check("R6 level gone", v, 32'h0);

        // R5 falling edge (code 00) on pin2
        pin_in[2] = 1; tick(3);
        rd(S_STAT, v); check("R5 fall ignores rise", v, 32'h0);
        pin_in[2] = 0; tick(3);
        rd(S_STAT, v); check("R5 fall", v, 32'h4);
        wr(S_STAT, A_CLR, 32'h4);

        // R5 low level (code 01) on pin3, already low
        wr(S_LVL, A_SET, 32'h8); tick(1);
        rd(S_STAT, v); check("R5 low level", v, 32'h8);
        pin_in[3] = 1; tick(3);
        wr(S_STAT, A_CLR, 32'h8);
        rd(S_STAT, v); check("R5 low level released", v, 32'h0);

        // R8 unselected pin8 in rising mode
        wr(S_POL, A_SET, 32'h100);
        pin_in[8] = 1; tick(3);
        rd(S_STAT, v); check("R8 unselected", v, 32'h0);
        check("R8 irq", {31'h0, irq}, 32'h0);

        // R9 enable masking on pin0
        pin_in[0] = 0; tick(3);
        wr(S_EN, A_CLR, 32'h1);
        pin_in[0] = 1; tick(3);
        rd(S_STAT, v); check("R9 status latched", v, 32'h1);
        check("R9 masked", {31'h0, irq}, 32'h0);
        wr(S_EN, A_SET, 32'h1);
        check("R9 unmasked", {31'h0, irq}, 32'h1);
        // R7 plain write of zeros does not clear
        wr(S_STAT, A_WR, 32'h0);
        rd(S_STAT, v); check("R7 sticky", v, 32'h1);

        // R10 set wins over clear in same cycle
        wr(S_STAT, A_CLR, 32'h1);
        pin_in[0] = 0; tick(3);
        rd(S_STAT, v); check("R10 precondition", v, 32'h0);
        pin_in[0] = 1; tick(2);
        wr(S_STAT, A_CLR, 32'h1);
        rd(S_STAT, v); check("R10 set wins", v, 32'h1);

        // R4 data-in synchroniser delay
        v = pin_in;
        pin_in = 32'hDEAD_BEEF;
        tick(1);
        begin
            logic [31:0] d;
            rd(S_DIN, d); check("R4 din old", d, v);
            tick(1);
            rd(S_DIN, d); check("R4 din new", d, 32'hDEAD_BEEF);
        end

        // R1 reset mid-run
        rst = 1; tick(2); rst = 0;
        reset_check("R1 mid-run");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule